// File: doc/BRIEF.md
# Synchronous Bus Read/Write Master

This block turns single-word read and write requests from a local user port into bus transfers with a fixed, clocked schedule. The schedule never varies, so every bus event falls on a known clock edge. No wait states, arbitration or bursts are involved. A transfer runs through three bus phases, one clock period each, and a fourth cycle returns the block to idle. During phase 1 the master presents the address. During phase 2 it raises the read strobe, or it drives the write data. During phase 3 a read returns its data from the slave, or the master raises the write strobe over data that has already settled.

The user raises a request with an operation select, an address and write data. The request is taken only while the master is idle. The master holds its own copy of the address and data for the whole transfer, and it pulses a done flag in the cycle after phase 3. A read result stays on the user read-data port until the next read finishes. A bus phase number is driven out with the strobes so that a slave can follow the schedule. A small memory slave that obeys the same schedule comes with the block and is used by the bench.

Top module: `sbus_master`

## Requirements
- R1: While reset (active low, synchronous) is held, and after it is released until a request arrives, bus_phase is 0, bus_rd, bus_wr and usr_done are 0, and bus_addr and bus_wdata are 0, even if usr_req is high.
- R2: A request sampled high while idle starts a transfer. In the next cycle bus_phase is 1 and bus_addr equals usr_addr as it was at that edge. bus_addr keeps that value through phase 3 and is 0 while idle.
- R3: bus_rd is high only in phase 2 of a read (usr_we=0 when the request was accepted) and never together with bus_wr.
- R4: The read data that the slave drives in phase 3 is captured at the end of phase 3 and appears on usr_rdata in the following cycle. usr_rdata holds that value until the next read completes.
- R5: For a write (usr_we=1), bus_wdata carries the accepted write data in phases 2 and 3 and is 0 at all other times.
- R6: bus_wr is high only in phase 3 of a write, and bus_wdata has then been unchanged since the previous cycle.
- R7: The memory slave stores bus_wdata at bus_addr on the edge that ends a cycle with bus_wr high. In the cycle after bus_rd is high it drives the addressed word on its read data, and it drives 0 in every other cycle.
- R8: usr_done is a single-cycle pulse in the cycle right after phase 3, once per transfer.
- R9: While a transfer is under way, requests and changes on usr_addr, usr_wdata and usr_we are ignored. The bus address and data stay those accepted at the start, and no extra transfer is started.
- R10: bus_phase steps 1, 2, 3, 0 on consecutive cycles. A request held high during the done cycle starts the next transfer at the following edge, so transfers can begin every 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all events on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| usr_req | input | 1 | Transfer request, taken when idle |
| usr_we | input | 1 | 1 = write, 0 = read |
| usr_addr | input | ADDR_W | Word address of the transfer |
| usr_wdata | input | DATA_W | Data for a write |
| usr_rdata | output | DATA_W | Last captured read data |
| usr_done | output | 1 | One-cycle pulse after a transfer ends |
| bus_addr | output | ADDR_W | Bus address, valid in phases 1 to 3 |
| bus_wdata | output | DATA_W | Bus write data, valid in phases 2 and 3 of a write |
| bus_rdata | input | DATA_W | Read data from the slave |
| bus_rd | output | 1 | Read strobe (phase 2) |
| bus_wr | output | 1 | Write strobe (phase 3) |
| bus_phase | output | 2 | Bus phase of the transfer, 0 when idle |

## Verification
On every cycle the assertions check the phase order, where the strobes may occur and that they never overlap. They also check that the address and write data hold still under the strobes, that done follows phase 3, and that the slave keeps its read data at zero unless a strobe came before. The bench shows what the properties cannot: that the accepted address and data are the ones the user supplied, and that a full sweep of writes and read-backs over every address returns the written words. Only the bench shows that user input changes and requests made during a transfer leave the bus untouched, and that requests held through the done cycle restart at the 4-cycle rate.

// File: rtl/sbus_pkg.sv
// Package: shared types of the synchronous bus master.
// Assumes a fixed three-phase transfer; the phase code is also the bus cycle count.
package sbus_pkg;
    localparam int PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2,
        PH_DATA = 2'd3
    } bus_phase_e;
endpackage

// File: rtl/sbus_mem_slave.sv
// Module: word memory slave that follows the fixed bus schedule.
// Answers a read strobe with data one cycle later and drives zero otherwise;
// stores write data on the edge that ends a write-strobe cycle.
// Assumes a single master and no wait states.
module sbus_mem_slave #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Purpose: store the word under the write strobe.
    always_ff @(posedge clk) begin
        if (bus_wr) begin
            mem_q[bus_addr] <= bus_wdata;
        end
    end

    // Purpose: return the addressed word one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= mem_q[bus_addr];
        end else begin
            bus_rdata <= '0;
        end
    end

    // R7
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == '0));
endmodule

// File: rtl/sbus_seq.sv
// Module: phase sequencer of the bus master.
// Steps idle -> address -> command -> data -> idle, one clock per phase,
// remembers the operation of the accepted request and makes the strobe enables.
// Assumes requests are only looked at while idle.
module sbus_seq
    import sbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       we_i,
    output bus_phase_e phase_o,
    output logic       accept_o,
    output logic       rd_stb_o,
    output logic       wr_stb_o,
    output logic       addr_en_o,
    output logic       wdata_en_o,
    output logic       capture_o,
    output logic       done_o
);
    bus_phase_e phase_q;
    logic       wr_q;
    logic       done_q;

    assign accept_o = (phase_q == PH_IDLE) && req_i;

    // Purpose: advance the phase and latch the operation at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_DATA);
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_i) begin
                        phase_q <= PH_ADDR;
                        wr_q    <= we_i;
                    end
                end
                PH_ADDR: phase_q <= PH_CMD;
                PH_CMD:  phase_q <= PH_DATA;
                PH_DATA: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Purpose: decode the per-phase enables of the schedule.
    always_comb begin
        rd_stb_o   = (phase_q == PH_CMD)  && !wr_q;
        wr_stb_o   = (phase_q == PH_DATA) && wr_q;
        addr_en_o  = (phase_q != PH_IDLE);
        wdata_en_o = wr_q && ((phase_q == PH_CMD) || (phase_q == PH_DATA));
        capture_o  = (phase_q == PH_DATA) && !wr_q;
    end

    assign phase_o = phase_q;
    assign done_o  = done_q;

    // R10
    phase_step1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ADDR) |=> (phase_q == PH_CMD));
    // R10
    phase_step2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CMD) |=> (phase_q == PH_DATA));
    // R10
    phase_step3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA) |=> (phase_q == PH_IDLE));
    // R8
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(phase_q) == PH_DATA));
    // R9
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) && ($past(phase_q) != PH_IDLE) |-> $stable(wr_q));
endmodule

// File: rtl/sbus_dpath.sv
// Module: address and data path of the bus master.
// Holds the accepted address and write data for the whole transfer, gates them
// onto the bus by phase, and captures read data at the end of the data phase.
// Assumes accept_i only pulses while the sequencer is idle.
module sbus_dpath #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic              addr_en_i,
    input  logic              wdata_en_i,
    input  logic [ADDR_W-1:0] usr_addr_i,
    input  logic [DATA_W-1:0] usr_wdata_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic [DATA_W-1:0] usr_rdata_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Purpose: take the user address and data when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept_i) begin
            addr_q  <= usr_addr_i;
            wdata_q <= usr_wdata_i;
        end
    end

    // Purpose: capture the slave's read data at the end of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture_i) begin
            rdata_q <= bus_rdata_i;
        end
    end

    // Purpose: drive address and write data only in their phases.
    always_comb begin
        bus_addr_o  = addr_en_i  ? addr_q  : '0;
        bus_wdata_o = wdata_en_i ? wdata_q : '0;
    end

    assign usr_rdata_o = rdata_q;

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en_i && $past(addr_en_i) |-> $stable(bus_addr_o));
    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture_i) |-> $stable(usr_rdata_o));
endmodule

// File: rtl/sbus_master.sv
// Module: synchronous bus read/write master (top).
// Runs one user request as a three-phase bus transfer: address, then read
// strobe or write data, then read data return or write strobe; pulses done after.
// Assumes a slave with no wait states that answers a read one cycle after the strobe.
module sbus_master
    import sbus_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               usr_req,
    input  logic               usr_we,
    input  logic [ADDR_W-1:0]  usr_addr,
    input  logic [DATA_W-1:0]  usr_wdata,
    output logic [DATA_W-1:0]  usr_rdata,
    output logic               usr_done,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rd,
    output logic               bus_wr,
    output logic [PHASE_W-1:0] bus_phase
);
    bus_phase_e phase;
    logic       accept;
    logic       addr_en;
    logic       wdata_en;
    logic       capture;

    sbus_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (usr_req),
        .we_i       (usr_we),
        .phase_o    (phase),
        .accept_o   (accept),
        .rd_stb_o   (bus_rd),
        .wr_stb_o   (bus_wr),
        .addr_en_o  (addr_en),
        .wdata_en_o (wdata_en),
        .capture_o  (capture),
        .done_o     (usr_done)
    );

    sbus_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .capture_i   (capture),
        .addr_en_i   (addr_en),
        .wdata_en_i  (wdata_en),
        .usr_addr_i  (usr_addr),
        .usr_wdata_i (usr_wdata),
        .bus_rdata_i (bus_rdata),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .usr_rdata_o (usr_rdata)
    );

    assign bus_phase = phase;

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    // R3
    rd_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_phase == 2'd2));
    // R6
    wr_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_phase == 2'd3));
    // R6
    wr_data_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $stable(bus_wdata));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 2'd0) |-> (bus_addr == '0) && (bus_wdata == '0));
endmodule

// File: tb/test_sbus_master.sv
// Bench: full write sweep then full read-back sweep over every address,
// with bus-level checks in each phase and disturbance of user inputs mid-transfer.
module test_sbus_master;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NWORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usr_req = 1'b0;
    logic          usr_we = 1'b0;
    logic [AW-1:0] usr_addr = '0;
    logic [DW-1:0] usr_wdata = '0;
    logic [DW-1:0] usr_rdata;
    logic          usr_done;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_rd;
    logic          bus_wr;
    logic [1:0]    bus_phase;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sbus_master #(.ADDR_W(AW), .DATA_W(DW)) i_sbus_master (
        .clk(clk), .rst_n(rst_n), .usr_req(usr_req), .usr_we(usr_we),
        .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
        .usr_done(usr_done), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_phase(bus_phase)
    );

    sbus_mem_slave #(.ADDR_W(AW), .DATA_W(DW)) i_slave (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 40503 + 777) ^ (a << 9));
    endfunction

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Enters and leaves on a falling edge while the master is idle.
    task automatic xfer(input bit we, input int a, input logic [DW-1:0] d,
                        input bit disturb);
        usr_req   = 1'b1;
        usr_we    = we;
        usr_addr  = AW'(a);
        usr_wdata = d;
        @(negedge clk);
        // phase 1
        chk(bus_phase == 2'd1, "R2 phase1", 32'(bus_phase), 1);
        chk(bus_addr == AW'(a), "R2 addr", 32'(bus_addr), 32'(a));
        chk(!bus_rd && !bus_wr, "R3 no strobe phase1", 32'({bus_rd, bus_wr}), 0);
        chk(bus_wdata == '0, "R5 wdata idle phase1", 32'(bus_wdata), 0);
        chk(!usr_done, "R8 done low phase1", 32'(usr_done), 0);
        if (disturb) begin
            usr_addr  = ~AW'(a);
            usr_wdata = ~d;
            usr_we    = ~we;
        end else begin
            usr_req = 1'b0;
        end
        @(negedge clk);
        // phase 2
        chk(bus_phase == 2'd2, "R10 phase2", 32'(bus_phase), 2);
        chk(bus_addr == AW'(a), "R9 addr held phase2", 32'(bus_addr), 32'(a));
        chk(bus_rd == !we, "R3 read strobe phase2", 32'(bus_rd), 32'(!we));
        chk(!bus_wr, "R6 no write strobe phase2", 32'(bus_wr), 0);
        chk(bus_wdata == (we ? d : '0), "R5 wdata phase2", 32'(bus_wdata),
            32'(we ? d : '0));
        @(negedge clk);
        // phase 3
        usr_req = 1'b0;
        chk(bus_phase == 2'd3, "R10 phase3", 32'(bus_phase), 3);
        chk(bus_addr == AW'(a), "R9 addr held phase3", 32'(bus_addr), 32'(a));
        chk(!bus_rd, "R3 read strobe dropped", 32'(bus_rd), 0);
        chk(bus_wr == we, "R6 write strobe phase3", 32'(bus_wr), 32'(we));
        chk(bus_wdata == (we ? d : '0), "R5 wdata phase3", 32'(bus_wdata),
            32'(we ? d : '0));
        if (!we) begin
            chk(bus_rdata == d, "R7 slave read data", 32'(bus_rdata), 32'(d));
        end
        @(negedge clk);
        // done cycle
        chk(usr_done, "R8 done pulse", 32'(usr_done), 1);
        chk(bus_phase == 2'd0, "R10 back to idle", 32'(bus_phase), 0);
        chk(bus_addr == '0, "R2 addr zero idle", 32'(bus_addr), 0);
        chk(bus_rdata == '0, "R7 slave quiet", 32'(bus_rdata), 0);
        if (!we) begin
            chk(usr_rdata == d, "R4 read result", 32'(usr_rdata), 32'(d));
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        usr_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_phase == 2'd0, "R1 reset phase", 32'(bus_phase), 0);
        chk(!bus_rd && !bus_wr && !usr_done, "R1 reset strobes",
            32'({bus_rd, bus_wr, usr_done}), 0);
        chk(bus_addr == '0 && bus_wdata == '0, "R1 reset bus", 32'(bus_addr), 0);
        usr_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(bus_phase == 2'd0, "R1 idle without request", 32'(bus_phase), 0);
        // write sweep, back to back, odd addresses disturbed
        for (int a = 0; a < NWORDS; a++) begin
            xfer(1'b1, a, pat(a), a[0]);
        end
        // read-back sweep in descending order
        for (int a = NWORDS - 1; a >= 0; a--) begin
            xfer(1'b0, a, pat(a), a[1]);
        end
        // R10: a request held through the done cycle restarts at once
        usr_req = 1'b1;
        usr_we = 1'b0;
        usr_addr = AW'(5);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(usr_done && usr_rdata == pat(5), "R10 first of pair", 32'(usr_rdata),
            32'(pat(5)));
        usr_addr = AW'(9);
        @(negedge clk);
        chk(bus_phase == 2'd1 && bus_addr == AW'(9), "R10 restart after done",
            32'(bus_phase), 1);
        usr_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(usr_done && usr_rdata == pat(9), "R4 second of pair", 32'(usr_rdata),
            32'(pat(9)));
        @(negedge clk);
        chk(!usr_done, "R8 single pulse", 32'(usr_done), 0);
        chk(usr_rdata == pat(9), "R4 result held", 32'(usr_rdata), 32'(pat(9)));
        repeat (4) @(negedge clk);
        chk(bus_phase == 2'd0, "R9 no extra transfer", 32'(bus_phase), 0);
        summary();
        $finish;
    end
endmodule